// File: doc/BRIEF.md
# Cache Flush and Sync Sequencer

This block walks every line of a small cache tag array when one of two active-low requests is seen while it is idle. A flush request writes every modified line back to memory, issues an inquire to the first-level cache with the invalidate flag set, and leaves every line invalid. A sync request also writes back modified lines and inquires the first-level cache, but without invalidation. A modified line becomes exclusive once its writeback is acknowledged, and the other lines keep their state.

One walker and one line index serve the state array, the writeback channel and the inquire channel. Lines are visited one at a time in ascending order. For each line the walker reads its state, performs at most one writeback and one inquire, and then updates the array. Each handshake waits for its acknowledge. The block moves no data.

Top module: `cache_sync_walker`

## Requirements
- R1: Out of reset, and whenever idle, busy, done, wb_req, inq_req and arr_we are all low.
- R2: A flush issues exactly one writeback for each line whose state is modified (code 3), with line_idx set to that line.
- R3: A flush issues one inquire per line with inq_inv high, and leaves every line in the invalid state (code 0).
- R4: A sync issues one writeback for each modified line and rewrites that line as exclusive (code 2). Lines in codes 0, 1 and 2 keep their value.
- R5: A sync issues one inquire per line with inq_inv low.
- R6: Lines are visited in ascending index order. At most one of wb_req and inq_req is high at a time. Each request, with its line_idx, holds until its acknowledge is seen.
- R7: When both requests go low in the same idle cycle, the walk is a flush.
- R8: A request that arrives while busy is ignored, and the running walk completes with its own result.
- R9: done is high for exactly one cycle at the end of a walk, and busy is low in the cycle after.
- R10: The array never receives a write of the modified code (3). State codes are I=0, S=1, E=2, M=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_n | input | 1 | Active-low flush request |
| sync_n | input | 1 | Active-low sync request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| line_idx | output | IDX_W | Current line, shared by array, writeback and inquire |
| wb_req | output | 1 | Writeback request for line_idx |
| wb_ack | input | 1 | Writeback acknowledge |
| inq_req | output | 1 | First-level cache inquire for line_idx |
| inq_inv | output | 1 | Inquire also invalidates (flush walk) |
| inq_ack | input | 1 | Inquire acknowledge |
| arr_rdata | input | 2 | State of line line_idx, combinational read |
| arr_we | output | 1 | State array write enable |
| arr_wdata | output | 2 | State written to line line_idx |

## Verification
The assertions take two things for granted. First, the state array returns the state of line_idx in the same cycle. Second, each acknowledge is raised only while its request is high and is dropped once the request falls. The bench models the array as a combinational read with a clocked write. Its responder raises an acknowledge only against a live request, after a delay of zero to two cycles that varies from one handshake to the next, and lowers it in the following cycle. Requests are driven as one-cycle pulses. In the busy-ignore case, the second pulse is placed in the middle of a walk.

// File: rtl/cache_sync_walker.sv
module cache_sync_walker #(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_n,
  input  logic             sync_n,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] line_idx,
  output logic             wb_req,
  input  logic             wb_ack,
  output logic             inq_req,
  output logic             inq_inv,
  input  logic             inq_ack,
  input  logic [1:0]       arr_rdata,
  output logic             arr_we,
  output logic [1:0]       arr_wdata
);
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  typedef enum logic [2:0] {IDLE, LOOK, WB, INQ, UPD, FIN} phase_t;

  phase_t           ph;
  logic [IDX_W-1:0] ptr;
  logic             is_flush;
  logic             was_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= IDLE;
      ptr      <= '0;
      is_flush <= 1'b0;
      was_m    <= 1'b0;
    end else begin
      case (ph)
        IDLE: if (!flush_n || !sync_n) begin
          ph       <= LOOK;
          ptr      <= '0;
          is_flush <= !flush_n;
        end
        LOOK: begin
          was_m <= (arr_rdata == ST_M);
          ph    <= (arr_rdata == ST_M) ? WB : INQ;
        end
        WB:  if (wb_ack) ph <= INQ;
        INQ: if (inq_ack) ph <= UPD;
        UPD: begin
          if (ptr == LAST) ph <= FIN;
          else begin
            ptr <= ptr + 1'b1;
            ph  <= LOOK;
          end
        end
        FIN:     ph <= IDLE;
        default: ph <= IDLE;
      endcase
    end
  end

  assign busy      = (ph != IDLE);
  assign done      = (ph == FIN);
  assign line_idx  = ptr;
  assign wb_req    = (ph == WB);
  assign inq_req   = (ph == INQ);
  assign inq_inv   = is_flush;
  assign arr_we    = (ph == UPD) && (is_flush || was_m);
  assign arr_wdata = is_flush ? ST_I : ST_E;
endmodule

module cache_sync_walker_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_n,
  input logic             sync_n,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] line_idx,
  input logic             wb_req,
  input logic             wb_ack,
  input logic             inq_req,
  input logic             inq_inv,
  input logic             inq_ack,
  input logic             arr_we,
  input logic [1:0]       arr_wdata
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wb_req && !inq_req && !arr_we && !done));
  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req && inq_req));
  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(line_idx)));
  a_r6_inq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inq_req && !inq_ack) |=> (inq_req && $stable(line_idx) && $stable(inq_inv)));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r8_start_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!flush_n || !sync_n));
  a_r10_no_m_write: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wdata != 2'd3));
endmodule

bind cache_sync_walker cache_sync_walker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .sync_n(sync_n),
  .busy(busy), .done(done), .line_idx(line_idx),
  .wb_req(wb_req), .wb_ack(wb_ack), .inq_req(inq_req),
  .inq_inv(inq_inv), .inq_ack(inq_ack),
  .arr_we(arr_we), .arr_wdata(arr_wdata)
);

// File: tb/sim_cache_sync_walker.sv
module sim_cache_sync_walker;
  localparam int LINES = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_n = 1'b1;
  logic sync_n = 1'b1;
  logic wb_ack = 1'b0;
  logic inq_ack = 1'b0;
  logic busy, done, wb_req, inq_req, inq_inv, arr_we;
  logic [IDX_W-1:0] line_idx;
  logic [1:0] arr_rdata, arr_wdata;

  logic [1:0] mem [LINES];
  logic [1:0] orig [LINES];

  int checks = 0;
  int errors = 0;
  int hs = 0;
  int wcnt = 0;
  int wb_n = 0;
  int inq_n = 0;
  int wb_log [64];
  int inq_log [64];
  int inv_log [64];
  int cycles = 0;

  always #2 clk = ~clk;

  cache_sync_walker #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .sync_n(sync_n),
    .busy(busy), .done(done), .line_idx(line_idx),
    .wb_req(wb_req), .wb_ack(wb_ack), .inq_req(inq_req),
    .inq_inv(inq_inv), .inq_ack(inq_ack), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_wdata(arr_wdata)
  );

  assign arr_rdata = mem[line_idx];
  always @(posedge clk) if (arr_we) mem[line_idx] <= arr_wdata;

  always @(negedge clk) begin
    if (wb_ack || inq_ack) begin
      wb_ack  <= 1'b0;
      inq_ack <= 1'b0;
      wcnt    <= 0;
    end else if (wb_req || inq_req) begin
      if (wcnt >= hs % 3) begin
        hs <= hs + 1;
        if (wb_req) begin
          wb_ack <= 1'b1;
          if (wb_n < 64) wb_log[wb_n] <= int'(line_idx);
          wb_n <= wb_n + 1;
        end else begin
          inq_ack <= 1'b1;
          if (inq_n < 64) begin
            inq_log[inq_n] <= int'(line_idx);
            inv_log[inq_n] <= int'(inq_inv);
          end
          inq_n <= inq_n + 1;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic load(input int p);
    for (int i = 0; i < LINES; i++) begin
      if (p == 0) orig[i] = 2'd3;
      else if (p == 1) orig[i] = 2'd0;
      else orig[i] = 2'((p * 5 + i * i + (p >> 1) * i) % 4);
      mem[i] = orig[i];
    end
  endtask

  task automatic run_walk(input bit fl, input bit sy, input int extra_at, input bit expect_flush);
    int seen = 0;
    int cyc = 0;
    int exp_wb = 0;
    int tail = 0;
    wb_n = 0;
    inq_n = 0;
    @(negedge clk);
    flush_n = !fl;
    sync_n = !sy;
    @(negedge clk);
    flush_n = 1'b1;
    sync_n = 1'b1;
    while (tail < 4 && cyc < 2000) begin
      if (done) seen++;
      if (seen > 0) tail++;
      @(negedge clk);
      cyc++;
      flush_n = 1'b1;
      if (cyc == extra_at) flush_n = 1'b0;
    end
    check(seen == 1, "R9 done pulses", seen, 1);
    check(!busy, "R9 busy after done", int'(busy), 0);
    for (int i = 0; i < LINES; i++) begin
      if (orig[i] == 2'd3) begin
        check(wb_n > exp_wb && wb_log[exp_wb] == i, "R6 writeback order",
              (wb_n > exp_wb) ? wb_log[exp_wb] : -1, i);
        exp_wb++;
      end
    end
    check(wb_n == exp_wb, expect_flush ? "R2 writeback count" : "R4 writeback count", wb_n, exp_wb);
    check(inq_n == LINES, expect_flush ? "R3 inquire count" : "R5 inquire count", inq_n, LINES);
    for (int i = 0; i < LINES && i < inq_n; i++) begin
      check(inq_log[i] == i, "R6 inquire order", inq_log[i], i);
      check(inv_log[i] == int'(expect_flush), expect_flush ? "R3 inquire invalidate" : "R5 inquire no invalidate",
            inv_log[i], int'(expect_flush));
    end
    for (int i = 0; i < LINES; i++) begin
      int e;
      if (expect_flush) e = 0;
      else e = (orig[i] == 2'd3) ? 2 : int'(orig[i]);
      check(int'(mem[i]) == e, expect_flush ? "R3 final state" : "R4 final state", int'(mem[i]), e);
      check(mem[i] != 2'd3 || !expect_flush, "R10 no modified left", int'(mem[i]), 0);
    end
  endtask

  initial begin
    load(1);
    repeat (3) @(negedge clk);
    check(!busy && !done && !wb_req && !inq_req && !arr_we, "R1 reset outputs",
          int'({busy, done, wb_req, inq_req, arr_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !wb_req && !inq_req && !arr_we, "R1 idle outputs",
          int'({busy, done, wb_req, inq_req, arr_we}), 0);

    for (int p = 0; p < 24; p++) begin
      load(p);
      if (p % 2 == 0) run_walk(1'b1, 1'b0, 0, 1'b1);
      else run_walk(1'b0, 1'b1, 0, 1'b0);
    end

    load(5);
    run_walk(1'b1, 1'b1, 0, 1'b1);   // R7 both requests at once
    load(6);
    run_walk(1'b0, 1'b1, 5, 1'b0);   // R8 flush pulse during a sync walk
    load(7);
    run_walk(1'b0, 1'b1, 17, 1'b0);  // R8 later in the walk

    repeat (2) @(negedge clk);
    check(!busy && !wb_req && !inq_req, "R1 quiet at end", int'({busy, wb_req, inq_req}), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule